// File: doc/BRIEF.md
# Banked GPIO Controller with Line Interrupts

This block drives and samples 24 general-purpose lines organised as three 8-bit banks. Line n lives in bank n/8 at bit n%8. Each line can be an input or an output. Output values are updated through a two-step masked write, so one bank bit can change without a read-modify-write of its neighbours. Each line can also raise an interrupt. The trigger is a rising edge, a falling edge, either edge, a high level or a low level. Interrupts are gated per line by an enable bit, latched edge events are acknowledged by writing 1s, and a single active-high request goes to the system.

Software reaches the block through a simple synchronous register port. The block leaves reset in a soft-reset state: every other register is held at zero, every line is an input and the request is low. It stays there until software clears the soft-reset bit. Pin inputs pass through a two-flop synchroniser, and a third flop keeps the previous sample for edge detection.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After `rst_ni` the soft-reset bit (address 0x3F, bit 0) reads 1. While it is 1, every other register is held at 0 and register writes other than to 0x3F have no effect. In that state `pin_oe_o`, `pin_o` and `irq_o` are 0.
- R2: The direction register of bank b is at address 0x06+b. Bit value 1 makes the line an output (`pin_oe_o` high) and 0 makes it an input.
- R3: A write to 0x00+2b stores a staged value byte. A following write to 0x01+2b updates only the output bits of bank b whose bit in that mask byte is 1. Output bits whose mask bit is 0 keep their value.
- R4: A read returns data on `rdata_o` one cycle after `re_i`, and `rdata_o` is 0 in any cycle after a cycle without `re_i`. Reading 0x00+2b returns the driven value for output lines and the synchronised pin for input lines.
- R5: With both-edges 0 and sense 0, a line latches a pending edge flag. It latches on a rising edge when its event bit is 1 and on a falling edge when its event bit is 0. An edge of the other direction does not set it.
- R6: With both-edges 1, a line latches on either edge and its sense and event bits have no effect.
- R7: With both-edges 0 and sense 1, a line's status is 1 exactly while the synchronised pin equals its event bit. Writing to the clear register cannot remove it.
- R8: The masked status of bank b (address 0x30+b) is pending status AND enable. `irq_o` is the OR of all masked status bits, and a line with enable 0 never raises `irq_o`.
- R9: Writing 1s to the clear register at 0x34+b clears the matching latched edge flags. 0 bits leave their flags unchanged.
- R10: The interrupt configuration registers are at 0x10 + 8*b + t and read back what was written. The type field t is 0 for both-edges, 1 for event (1 = rising/high), 2 for sense (1 = level) and 3 for enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, one cycle after re_i |
| pin_i | input | 24 | Pin inputs, asynchronous |
| pin_o | output | 24 | Driven output values |
| pin_oe_o | output | 24 | Per-pin output enable |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The checker watches, on every cycle, that soft reset forces the outputs and request low. It also checks that idle cycles return zero read data, that the driven pins move only after a mask write, that direction writes reach the output enables and that a fully disabled enable set keeps the request low. The trigger semantics cannot be shown by those cycle checks: edge direction, the both-edges override, level status that survives acknowledge, and clearing of latched flags. The bench shows them with directed pin sequences. Mixed input and output readback is exercised by random masked writes, direction changes and pin patterns against a bench model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_BASE  = 8'h00;
  localparam int DIR_BASE   = 8'h06;
  localparam int CFG_BASE   = 8'h10;
  localparam int CFG_STRIDE = 8;
  localparam int MIS_BASE   = 8'h30;
  localparam int CLR_BASE   = 8'h34;
  localparam int RST_ADDR   = 8'h3F;

  typedef enum logic [1:0] {
    CFG_BOTH  = 2'd0,
    CFG_EVENT = 2'd1,
    CFG_SENSE = 2'd2,
    CFG_EN    = 2'd3
  } cfg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else if (hold_i) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur_o  = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic cur_i,
  input  logic prev_i,
  input  logic both_i,
  input  logic evt_i,
  input  logic sense_i,
  input  logic clr_i,
  output logic pend_o
);
  logic rise, fall, edge_hit, level_hit, flag_q;

  assign rise      = cur_i & ~prev_i;
  assign fall      = ~cur_i & prev_i;
  assign edge_hit  = both_i ? (rise | fall) : (~sense_i & (evt_i ? rise : fall));
  assign level_hit = ~both_i & sense_i & (cur_i == evt_i);

  // a new edge wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (hold_i)   flag_q <= 1'b0;
    else if (edge_hit) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign pend_o = flag_q | level_hit;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NB = 3,
  parameter int BW = 8,
  parameter int AW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic [BW-1:0]      wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [BW-1:0]      rdata_o,
  input  logic [NB*BW-1:0]   pin_i,
  output logic [NB*BW-1:0]   pin_o,
  output logic [NB*BW-1:0]   pin_oe_o,
  output logic               irq_o
);
  localparam int N = NB * BW;

  logic          srst_q;
  logic [N-1:0]  out_q, dir_q, both_q, evt_q, sense_q, en_q, stage_q;
  logic [N-1:0]  clr_vec, pend, sync_cur, sync_prev, mis;
  logic [BW-1:0] rmux, rdata_q;

  function automatic logic hit(input logic [AW-1:0] a, input int t);
    return int'(a) == t;
  endfunction

  gpio_sync #(.W(N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (srst_q),
    .d_i    (pin_i),
    .cur_o  (sync_cur),
    .prev_o (sync_prev)
  );

  for (genvar i = 0; i < N; i++) begin : g_line
    gpio_line_detect u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hold_i  (srst_q),
      .cur_i   (sync_cur[i]),
      .prev_i  (sync_prev[i]),
      .both_i  (both_q[i]),
      .evt_i   (evt_q[i]),
      .sense_i (sense_q[i]),
      .clr_i   (clr_vec[i]),
      .pend_o  (pend[i])
    );
  end

  always_comb begin
    clr_vec = '0;
    for (int b = 0; b < NB; b++)
      if (we_i && !srst_q && hit(addr_i, CLR_BASE + b))
        clr_vec[b*BW +: BW] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q  <= 1'b1;
      out_q   <= '0;
      dir_q   <= '0;
      both_q  <= '0;
      evt_q   <= '0;
      sense_q <= '0;
      en_q    <= '0;
      stage_q <= '0;
    end else begin
      if (we_i && hit(addr_i, RST_ADDR)) srst_q <= wdata_i[0];
      if (srst_q) begin
        out_q   <= '0;
        dir_q   <= '0;
        both_q  <= '0;
        evt_q   <= '0;
        sense_q <= '0;
        en_q    <= '0;
        stage_q <= '0;
      end else if (we_i) begin
        for (int b = 0; b < NB; b++) begin
          if (hit(addr_i, DATA_BASE + 2*b))
            stage_q[b*BW +: BW] <= wdata_i;
          if (hit(addr_i, DATA_BASE + 2*b + 1))
            out_q[b*BW +: BW] <= (out_q[b*BW +: BW] & ~wdata_i) |
                                 (stage_q[b*BW +: BW] & wdata_i);
          if (hit(addr_i, DIR_BASE + b))
            dir_q[b*BW +: BW] <= wdata_i;
          if (hit(addr_i, CFG_BASE + CFG_STRIDE*b + int'(CFG_BOTH)))
            both_q[b*BW +: BW] <= wdata_i;
          if (hit(addr_i, CFG_BASE + CFG_STRIDE*b + int'(CFG_EVENT)))
            evt_q[b*BW +: BW] <= wdata_i;
          if (hit(addr_i, CFG_BASE + CFG_STRIDE*b + int'(CFG_SENSE)))
            sense_q[b*BW +: BW] <= wdata_i;
          if (hit(addr_i, CFG_BASE + CFG_STRIDE*b + int'(CFG_EN)))
            en_q[b*BW +: BW] <= wdata_i;
        end
      end
    end
  end

  assign mis = pend & en_q;

  always_comb begin
    rmux = '0;
    if (hit(addr_i, RST_ADDR)) rmux = {{(BW-1){1'b0}}, srst_q};
    for (int b = 0; b < NB; b++) begin
      if (hit(addr_i, DATA_BASE + 2*b))
        rmux = (dir_q[b*BW +: BW] & out_q[b*BW +: BW]) |
               (~dir_q[b*BW +: BW] & sync_cur[b*BW +: BW]);
      if (hit(addr_i, DIR_BASE + b)) rmux = dir_q[b*BW +: BW];
      if (hit(addr_i, CFG_BASE + CFG_STRIDE*b + int'(CFG_BOTH)))  rmux = both_q[b*BW +: BW];
      if (hit(addr_i, CFG_BASE + CFG_STRIDE*b + int'(CFG_EVENT))) rmux = evt_q[b*BW +: BW];
      if (hit(addr_i, CFG_BASE + CFG_STRIDE*b + int'(CFG_SENSE))) rmux = sense_q[b*BW +: BW];
      if (hit(addr_i, CFG_BASE + CFG_STRIDE*b + int'(CFG_EN)))    rmux = en_q[b*BW +: BW];
      if (hit(addr_i, MIS_BASE + b)) rmux = mis[b*BW +: BW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= re_i ? rmux : '0;
  end

  assign rdata_o  = rdata_q;
  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |mis;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NB = 3,
  parameter int BW = 8,
  parameter int AW = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [AW-1:0]      addr_i,
  input logic [BW-1:0]      wdata_i,
  input logic               we_i,
  input logic               re_i,
  input logic [BW-1:0]      rdata_o,
  input logic [NB*BW-1:0]   pin_o,
  input logic [NB*BW-1:0]   pin_oe_o,
  input logic               irq_o,
  input logic               srst_q,
  input logic [NB*BW-1:0]   en_q
);
  logic mask_wr, dir0_wr;
  assign mask_wr = we_i && addr_i[0] && (int'(addr_i) < 2*NB);
  assign dir0_wr = we_i && !srst_q && (int'(addr_i) == gpio_pkg::DIR_BASE);

  // R1
  soft_reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (pin_oe_o == '0 && pin_o == '0 && !irq_o));

  // R2
  dir_to_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir0_wr |=> pin_oe_o[BW-1:0] == $past(wdata_i));

  // R3
  pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_wr && !srst_q) |=> $stable(pin_o));

  // R4
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> rdata_o == '0);

  // R8
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NB(NB), .BW(BW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .rdata_o  (rdata_o),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o),
  .srst_q   (srst_q),
  .en_q     (en_q)
);

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        we = 1'b0, re = 1'b0;
  logic [23:0] pins = '0, pin_o, pin_oe;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  logic [23:0] out_m = '0, dir_m = '0;

  always #4 clk = ~clk;

  gpio_bank_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pin_i(pins),
    .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_data(input int b);
    return (dir_m[b*8 +: 8] & out_m[b*8 +: 8]) | (~dir_m[b*8 +: 8] & pins[b*8 +: 8]);
  endfunction

  function automatic logic [7:0] cfg_addr(input int b, input int t);
    return 8'(16 + 8*b + t);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: soft reset state and ignored writes
    rd(8'h3F, v); check("R1 rst bit", v, 1);
    check("R1 oe", pin_oe, 0); check("R1 irq", irq, 0);
    wr(8'h06, 8'hFF); wr(8'h00, 8'hFF); wr(8'h01, 8'hFF);
    rd(8'h06, v); check("R1 dir ignored", v, 0);
    check("R1 oe held", pin_oe, 0); check("R1 pins held", pin_o, 0);
    wr(8'h3F, 8'h00);
    rd(8'h3F, v); check("R1 rst cleared", v, 0);
    // R4: idle cycle read data
    @(negedge clk); check("R4 idle rdata", rdata, 0);

    // R2 R3 R4: random masked writes, directions and pins
    for (int it = 0; it < 150; it++) begin
      int b = $urandom_range(0, 2);
      case ($urandom_range(0, 2))
        0: begin
          logic [7:0] val = 8'($urandom), msk = 8'($urandom);
          wr(8'(2*b), val); wr(8'(2*b + 1), msk);
          out_m[b*8 +: 8] = (out_m[b*8 +: 8] & ~msk) | (val & msk);
        end
        1: begin
          logic [7:0] d = 8'($urandom);
          wr(8'(6 + b), d); dir_m[b*8 +: 8] = d;
        end
        default: pins = 24'($urandom);
      endcase
      settle();
      rd(8'(2*b), v); check("R4 data readback", v, exp_data(b));
      check("R3 pin_o", pin_o, out_m);
      check("R2 pin_oe", pin_oe, dir_m);
    end
    // R3: zero mask keeps outputs
    wr(8'h02, 8'hA5); wr(8'h03, 8'h00);
    check("R3 zero mask", pin_o, out_m);
    wr(8'h02, 8'h0F); wr(8'h03, 8'h3C);
    out_m[15:8] = (out_m[15:8] & ~8'h3C) | (8'h0F & 8'h3C);
    check("R3 partial mask", pin_o, out_m);

    // interrupts: quiet pins, clear stale flags
    pins = '0; settle();
    for (int b = 0; b < 3; b++) wr(8'(52 + b), 8'hFF);

    // R5 rising edge on line 0
    wr(cfg_addr(0, 1), 8'h01); wr(cfg_addr(0, 3), 8'h01);
    pins[0] = 1'b1; settle();
    rd(8'h30, v); check("R5 rise latched", v, 8'h01); check("R8 irq", irq, 1);
    wr(8'h34, 8'h01); settle();
    rd(8'h30, v); check("R9 cleared", v, 0); check("R9 irq low", irq, 0);
    pins[0] = 1'b0; settle();
    rd(8'h30, v); check("R5 fall ignored", v, 0);
    // R5 falling edge mode
    wr(cfg_addr(0, 1), 8'h00);
    pins[0] = 1'b1; settle();
    rd(8'h30, v); check("R5 rise ignored", v, 0);
    pins[0] = 1'b0; settle();
    rd(8'h30, v); check("R5 fall latched", v, 8'h01);
    wr(8'h34, 8'h01);

    // R6 both edges on line 10, sense set but ignored
    wr(cfg_addr(1, 0), 8'h04); wr(cfg_addr(1, 2), 8'h04); wr(cfg_addr(1, 3), 8'h04);
    settle();
    rd(8'h31, v); check("R6 sense ignored", v, 0);
    pins[10] = 1'b1; settle();
    rd(8'h31, v); check("R6 rise", v, 8'h04);
    wr(8'h35, 8'h04);
    rd(8'h31, v); check("R9 clear bank1", v, 0);
    pins[10] = 1'b0; settle();
    rd(8'h31, v); check("R6 fall", v, 8'h04);
    wr(8'h35, 8'h04);
    rd(cfg_addr(1, 0), v); check("R10 both readback", v, 8'h04);
    rd(cfg_addr(1, 2), v); check("R10 sense readback", v, 8'h04);

    // R7 low level on line 20
    wr(cfg_addr(2, 2), 8'h10); wr(cfg_addr(2, 3), 8'h10); settle();
    rd(8'h32, v); check("R7 low level", v, 8'h10);
    wr(8'h36, 8'h10);
    rd(8'h32, v); check("R7 clear no effect", v, 8'h10);
    pins[20] = 1'b1; settle();
    rd(8'h32, v); check("R7 level gone", v, 0);
    wr(cfg_addr(2, 1), 8'h10); settle();
    rd(8'h32, v); check("R7 high level", v, 8'h10);
    wr(cfg_addr(2, 3), 8'h00);
    rd(8'h32, v); check("R8 disabled", v, 0);

    // R8 latched flag hidden by enable
    wr(cfg_addr(0, 3), 8'h00);
    pins[0] = 1'b1; settle(); pins[0] = 1'b0; settle();
    rd(8'h30, v); check("R8 masked", v, 0); check("R8 irq off", irq, 0);
    wr(cfg_addr(0, 3), 8'h01);
    rd(8'h30, v); check("R8 revealed", v, 8'h01); check("R8 irq on", irq, 1);
    rd(cfg_addr(0, 3), v); check("R10 en readback", v, 8'h01);
    wr(8'h34, 8'h01);
    rd(8'h30, v); check("R9 final clear", v, 0);

    report();
  end
endmodule